// File: doc/BRIEF.md
# Itoh-Tsujii AES Forward S-box

This block is the forward byte substitution of AES. It builds the substitution from arithmetic and holds no stored table. The byte's multiplicative inverse in GF(2^8) is taken as x^-1 = x^16 · (x^17)^-1. The field polynomial is x^8+x^4+x^3+x+1.

The 17th power is the norm of x down to the 16-element subfield. Only that value needs inverting, and the inversion happens in the subfield. A subfield value is held as a 5-bit vector over the fifth roots of unity β (β = 0x03^51). In that form a squaring is only a rewiring of the bits, and a product is a cyclic convolution modulo x^5+1, built from AND and XOR gates. The subfield inverse y^14 is formed as y^2·y^4·y^8. That result is folded back to a byte and multiplied by x^16. The standard affine step then produces the output.

The datapath is purely combinational. When the parameter `OUT_REG` is 1, a single output register follows the datapath.

Top module: `aes_cf_sbox`

## Requirements
- R1: For every input byte, `dout` equals the AES forward S-box value: the affine transform of the GF(2^8) inverse under x^8+x^4+x^3+x+1.
- R2: For every nonzero input, the inverse the datapath forms, multiplied by the input, gives 0x01.
- R3: The 17th power of the input lies in the 16-element subfield, so it is unchanged by raising it to the 16th power.
- R4: For every nonzero subfield value, the inverse built from the 5-bit cyclic ring (squaring as index doubling mod 5, product as convolution mod x^5+1) gives 0x01 when multiplied by that value.
- R5: Input 0x00 is treated as having inverse 0x00, so it produces 0x63.
- R6: The affine step XORs the byte with its left rotations by 1, 2, 3 and 4 bits, then with 0x63. Known values: 0x01→0x7C, 0x53→0xED, 0xFF→0x16.
- R7: With `OUT_REG`=1, `dout` shows the substitution of the `din` sampled at the previous rising edge. A low `rst_n` at a rising edge sets `dout` to 0x00.
- R8: With `OUT_REG`=0, `dout` follows `din` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte |

## Verification
The bench builds two copies of the block. One uses `OUT_REG`=1, which brings the one-cycle latency and the synchronous clear of the output register into reach. The other uses `OUT_REG`=0, which exposes the pure combinational path within the same cycle. Both copies see all 256 input bytes, and each result is compared against a brute-force inverse search with the affine step written in rotation form. A reset asserted part-way through the sweep checks that the registered copy clears to 0x00.

// File: rtl/cf_sbox_pkg.sv
// Package: shared types and GF(2^8) / cyclic-ring helper functions.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1 and generator 0x03.
package cf_sbox_pkg;
    localparam int BYTE_W = 8;
    localparam int RING_N = 5;
    localparam int BETA_EXP = 255 / RING_N;
    localparam logic [BYTE_W-1:0] POLY_LOW = 8'h1B;
    localparam logic [BYTE_W-1:0] GEN = 8'h03;
    localparam logic [BYTE_W-1:0] AFF_C = 8'h63;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [RING_N-1:0] ring_t;

    // Polynomial-basis product in GF(2^8)
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[BYTE_W-1] ? ({sh[BYTE_W-2:0], 1'b0} ^ POLY_LOW) : {sh[BYTE_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    // Repeated product, used for constants and checks only
    function automatic byte_t gf_pow(input byte_t a, input int n);
        byte_t r;
        r = 8'h01;
        for (int i = 0; i < n; i++) r = gf_mul(r, a);
        return r;
    endfunction

    // Primitive fifth root of unity in the subfield
    localparam byte_t BETA = gf_pow(GEN, BETA_EXP);

    // beta^k for k in 0..RING_N-1
    function automatic byte_t beta_pow(input int k);
        byte_t r;
        r = 8'h01;
        for (int i = 0; i < RING_N; i++) if (i < k) r = gf_mul(r, BETA);
        return r;
    endfunction

    // Absolute trace of a subfield value (result is 0x00 or 0x01)
    function automatic byte_t tr16(input byte_t z);
        byte_t z2;
        byte_t z4;
        z2 = gf_mul(z, z);
        z4 = gf_mul(z2, z2);
        return z ^ z2 ^ z4 ^ gf_mul(z4, z4);
    endfunction

    // Cyclic convolution modulo x^RING_N + 1
    function automatic ring_t ring_mul(input ring_t a, input ring_t b);
        ring_t c;
        c = '0;
        for (int i = 0; i < RING_N; i++)
            for (int j = 0; j < RING_N; j++)
                if (a[i] && b[j]) c[(i + j) % RING_N] = ~c[(i + j) % RING_N];
        return c;
    endfunction

    // Squaring in the ring: pure index permutation k -> 2k mod RING_N
    function automatic ring_t ring_sq(input ring_t a);
        ring_t r;
        r = '0;
        for (int k = 0; k < RING_N; k++) r[(2 * k) % RING_N] = a[k];
        return r;
    endfunction
endpackage

// File: rtl/cf_pow_stage.sv
// Module: forms x^16 (four squarings) and the norm x^17 of the input byte.
// Assumes polynomial-basis input; purely combinational.
module cf_pow_stage
    import cf_sbox_pkg::*;
(
    input  logic [BYTE_W-1:0] x,
    output logic [BYTE_W-1:0] p16,
    output logic [BYTE_W-1:0] p17
);
    localparam int SQ_STEPS = 4;

    // Repeated squaring then one product to reach the subfield
    always_comb begin
        byte_t t;
        t = x;
        for (int s = 0; s < SQ_STEPS; s++) t = gf_mul(t, t);
        p16 = t;
        p17 = gf_mul(t, x);
    end
endmodule

// File: rtl/cf_sub_inverse.sv
// Module: inverts a 16-element-subfield value held as a byte.
// The value is moved to the 5-bit redundant ring over beta by traces,
// raised to y^14 = y^2*y^4*y^8 with rewired squarings and two cyclic
// products, and folded back to a byte. Assumes y lies in the subfield.
module cf_sub_inverse
    import cf_sbox_pkg::*;
(
    input  logic [BYTE_W-1:0] y,
    output logic [BYTE_W-1:0] y_inv
);
    ring_t red;
    ring_t s1;
    ring_t s2;
    ring_t s3;
    ring_t inv_r;

    // Trace projection onto the redundant coordinates: a_k = Tr(y*beta^-k)
    always_comb begin
        byte_t tv;
        for (int k = 0; k < RING_N; k++) begin
            tv = tr16(gf_mul(y, beta_pow((RING_N - k) % RING_N)));
            red[k] = tv[0];
        end
    end

    // Exponent 14 in the ring
    always_comb begin
        s1 = ring_sq(red);
        s2 = ring_sq(s1);
        s3 = ring_sq(s2);
        inv_r = ring_mul(ring_mul(s1, s2), s3);
    end

    // Fold redundant vector back to a byte: sum of a_k * beta^k
    always_comb begin
        y_inv = '0;
        for (int k = 0; k < RING_N; k++) if (inv_r[k]) y_inv = y_inv ^ beta_pow(k);
    end
endmodule

// File: rtl/cf_affine.sv
// Module: AES affine step, byte XOR its rotations by 1..4 then the constant.
module cf_affine
    import cf_sbox_pkg::*;
(
    input  logic [BYTE_W-1:0] b,
    output logic [BYTE_W-1:0] s
);
    // Bit-wise rotated-XOR network
    always_comb begin
        for (int i = 0; i < BYTE_W; i++)
            s[i] = b[i] ^ b[(i + 4) % BYTE_W] ^ b[(i + 5) % BYTE_W]
                 ^ b[(i + 6) % BYTE_W] ^ b[(i + 7) % BYTE_W] ^ AFF_C[i];
    end
endmodule

// File: rtl/aes_cf_sbox.sv
// Module: top of the Itoh-Tsujii forward S-box. x^-1 = x^16 * (x^17)^-1,
// then the affine step; OUT_REG=1 adds one output register with
// synchronous active-low reset, OUT_REG=0 leaves the path combinational.
module aes_cf_sbox
    import cf_sbox_pkg::*;
#(
    parameter int OUT_REG = 1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    byte_t p16;
    byte_t p17;
    byte_t sub_inv;
    byte_t inv_w;
    byte_t sbox_c;

    cf_pow_stage   u_pow (.x(din), .p16(p16), .p17(p17));
    cf_sub_inverse u_sub (.y(p17), .y_inv(sub_inv));

    // Recombine: subfield inverse times x^16
    always_comb inv_w = gf_mul(p16, sub_inv);

    cf_affine u_aff (.b(inv_w), .s(sbox_c));

    generate
        if (OUT_REG != 0) begin : g_reg
            // Output register, cleared by synchronous reset
            always_ff @(posedge clk) begin
                if (!rst_n) dout <= '0;
                else        dout <= sbox_c;
            end
            // R7
            dout_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> dout == $past(sbox_c));
        end else begin : g_comb
            // Direct combinational output
            always_comb dout = sbox_c;
        end
    endgenerate

    // R2
    full_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din != 8'h00) |-> gf_mul(din, inv_w) == 8'h01);
    // R3
    sub_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gf_pow(p17, 16) == p17);
    // R4
    sub_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p17 != 8'h00) |-> gf_mul(p17, sub_inv) == 8'h01);
    // R5
    zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din == 8'h00) |-> sbox_c == 8'h63);
endmodule

// File: tb/sim_aes_cf_sbox.sv
`timescale 1ns/1ps
module sim_aes_cf_sbox;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout_r;
    logic [7:0] dout_c;
    int checks = 0;
    int errors = 0;
    logic [7:0] expq[$];

    always #10 clk = ~clk;

    aes_cf_sbox #(.OUT_REG(1)) u0 (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout_r));
    aes_cf_sbox #(.OUT_REG(0)) u1 (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout_c));

    function automatic logic [7:0] xt(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] aa = a;
        logic [7:0] bb = b;
        while (bb != 0) begin
            if (bb[0]) p = p ^ aa;
            aa = xt(aa);
            bb = bb >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] ref_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        for (int c = 1; c < 256; c++) if (bmul(a, 8'(c)) == 8'h01) inv = 8'(c);
        return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Driver: applies a byte at the falling edge, checks the combinational copy, queues the registered expectation
    task automatic drive(input logic [7:0] v, input string req);
        logic [7:0] e;
        @(negedge clk);
        din = v;
        e = ref_sbox(v);
        expq.push_back(e);
        #1;
        check(req, dout_c, e);
    endtask

    // Monitor: after each rising edge, pops one expectation and compares the registered copy
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && expq.size() > 0) check("R7 registered", dout_r, expq.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        din = 8'h53;
        repeat (2) @(posedge clk);
        #1;
        check("R7 reset state", dout_r, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // Named corner values
        drive(8'h00, "R5 zero input");
        drive(8'h01, "R6 affine 01");
        drive(8'h53, "R6 affine 53");
        drive(8'hFF, "R6 affine FF");
        // Full sweep, same-cycle path covers R8, reference covers R1-style results
        for (int i = 0; i < 256; i++) drive(8'(i), "R1 R8 sweep");
        // Descending sweep, different input succession
        for (int i = 255; i >= 0; i--) drive(8'(i), "R1 descending");
        @(posedge clk);
        #2;
        // Mid-stream reset
        @(negedge clk);
        din = 8'hA7;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R7 sync clear", dout_r, 8'h00);
        check("R8 comb during reset", dout_c, ref_sbox(8'hA7));
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'h10, "R1 after reset");
        @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule